// File: doc/BRIEF.md
# Software Store/Recall Unlock Detector

This block watches completed memory access cycles on a 16-bit address bus and recognises a fixed six-read unlock pattern. The first five reads must hit a shared prefix of key addresses, in order. The address of the sixth read selects the operation. One address requests a nonvolatile store. Another address requests a recall. Any write, or any read that leaves the pattern, cancels the progress made so far. On a full match the block issues one-cycle start pulses to the external store and recall engines, and it holds an I/O-disable flag high until those engines report that they have finished.

A read counts when either of two strobe events marks it complete: one delimited by chip enable, or one delimited by output enable. A read delimited by chip enable counts even when output enable stays inactive. A store is issued as two ordered sub-commands. The erase command goes first. The program command follows after the engine reports that the erase is done. A recall is a single command. While the flag is high, every access is ignored. Each done report also clears any partial progress.

Top module: `su_unlock_top`

## Requirements
- R1: After reset, erase_start, prog_start and recall_start are low, io_dis is low, and no pattern progress is held.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F followed by a read at 0x8FC0 give a one-cycle erase_start pulse in the cycle after the sixth read is sampled. io_dis rises in the same cycle.
- R3: The same five reads followed by a read at 0x4C63 give a one-cycle recall_start pulse in the cycle after the sixth read is sampled, and io_dis rises.
- R4: During a store, the first op_done gives a one-cycle prog_start pulse in the following cycle while io_dis stays high. The second op_done lowers io_dis in the following cycle.
- R5: During a recall, op_done lowers io_dis in the following cycle, and no other pulse is produced.
- R6: A write at any point in the pattern cancels it, so completing the remaining reads starts nothing.
- R7: A read at an address other than the expected next one cancels the pattern.
- R8: A read at 0x4E38 that breaks the pattern counts as the first step of a new pattern, including when it arrives in place of the sixth read.
- R9: A read counts when ce_rd or oe_rd is high. Both high in the same cycle count as one read.
- R10: While io_dis is high, reads and writes have no effect: no pulse, and no progress that survives the release.
- R11: op_done while the block is idle produces no pulse and clears any partial pattern progress.
- R12: A sixth read that matches neither operation address starts nothing. A later full pattern still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_rd | input | 1 | One-cycle event: a read delimited by chip enable completed |
| oe_rd | input | 1 | One-cycle event: a read delimited by output enable completed |
| wr_evt | input | 1 | One-cycle event: a write completed |
| acc_addr | input | 16 | Address of the access flagged this cycle |
| op_done | input | 1 | One-cycle report from the engine that the current sub-operation finished |
| erase_start | output | 1 | One-cycle command to erase the nonvolatile array |
| prog_start | output | 1 | One-cycle command to program the nonvolatile array from SRAM |
| recall_start | output | 1 | One-cycle command to recall nonvolatile contents |
| io_dis | output | 1 | High while an operation is in progress; the host's I/O is blocked |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a five-entry prefix and the two operation keys listed above. With these defaults the first prefix key can also appear as a breaking read. That makes the restart-at-step-two path reachable, both in the middle of the prefix and in the sixth position. The expected command pulses are queued with the cycle in which each should appear. This checks the exact one-cycle latency of every start pulse, and it also reports any pulse that arrives when none is queued.

// File: rtl/su_pkg.sv
package su_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_PROG   = 2'd2,
    OP_RECALL = 2'd3
  } op_state_e;
endpackage

// File: rtl/su_rst_sync.sv
module su_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/su_match.sv
module su_match #(
  parameter int ADDR_W = 16,
  parameter int NPRE   = 5,
  parameter logic [NPRE*ADDR_W-1:0] PREFIX = '0,
  parameter logic [ADDR_W-1:0] KEY_ST = '0,
  parameter logic [ADDR_W-1:0] KEY_RC = '0
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blocked,
  input  logic              op_done,
  output logic              hit_store,
  output logic              hit_recall
);
  localparam int STEP_W = $clog2(NPRE + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NPRE);

  logic [STEP_W-1:0] step_q, step_n;
  logic [NPRE:0]     pre_eq;
  logic              key_st_eq, key_rc_eq;
  logic              step_en;

  // one comparator per prefix entry; top slot never matches
  for (genvar gi = 0; gi < NPRE; gi++) begin : g_cmp
    assign pre_eq[gi] = (addr == PREFIX[gi*ADDR_W +: ADDR_W]);
  end
  assign pre_eq[NPRE] = 1'b0;

  assign key_st_eq = (addr == KEY_ST);
  assign key_rc_eq = (addr == KEY_RC);

  always_comb begin
    step_n     = step_q;
    hit_store  = 1'b0;
    hit_recall = 1'b0;
    if (op_done) begin
      step_n = '0;
    end else if (!blocked && acc_wr) begin
      step_n = '0;
    end else if (!blocked && acc_rd) begin
      if (step_q == LAST) begin
        hit_store  = key_st_eq;
        hit_recall = key_rc_eq && !key_st_eq;
        if (key_st_eq || key_rc_eq) step_n = '0;
        else                        step_n = pre_eq[0] ? STEP_W'(1) : '0;
      end else if (pre_eq[step_q]) begin
        step_n = step_q + STEP_W'(1);
      end else begin
        step_n = pre_eq[0] ? STEP_W'(1) : '0;
      end
    end
  end

  assign step_en = (step_n != step_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      step_q <= '0;
    else if (step_en) step_q <= step_n;
  end

  // R1: progress never exceeds the prefix length
  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_sn)
    step_q <= LAST);
  // R6: an unblocked write leaves no progress
  a_r6_wr_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    (!blocked && acc_wr) |=> (step_q == '0));
  // R10: blocked accesses cannot advance the pattern
  a_r10_blocked_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (blocked && !op_done) |=> $stable(step_q));
  // R11: a done report clears progress
  a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    op_done |=> (step_q == '0));
endmodule

// File: rtl/su_opseq.sv
module su_opseq
  import su_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic hit_store,
  input  logic hit_recall,
  input  logic op_done,
  output logic erase_go,
  output logic prog_go,
  output logic recall_go,
  output logic busy
);
  op_state_e st_q, st_n;
  logic erase_n, prog_n, recall_n;

  always_comb begin
    st_n     = st_q;
    erase_n  = 1'b0;
    prog_n   = 1'b0;
    recall_n = 1'b0;
    unique case (st_q)
      OP_IDLE: begin
        if (hit_store) begin
          st_n    = OP_ERASE;
          erase_n = 1'b1;
        end else if (hit_recall) begin
          st_n     = OP_RECALL;
          recall_n = 1'b1;
        end
      end
      OP_ERASE: begin
        if (op_done) begin
          st_n   = OP_PROG;
          prog_n = 1'b1;
        end
      end
      OP_PROG:   if (op_done) st_n = OP_IDLE;
      OP_RECALL: if (op_done) st_n = OP_IDLE;
      default:   st_n = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q      <= OP_IDLE;
      erase_go  <= 1'b0;
      prog_go   <= 1'b0;
      recall_go <= 1'b0;
    end else begin
      st_q      <= st_n;
      erase_go  <= erase_n;
      prog_go   <= prog_n;
      recall_go <= recall_n;
    end
  end

  assign busy = (st_q != OP_IDLE);

  // R2: at most one command per cycle
  a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({erase_go, prog_go, recall_go}));
  // R2: erase command lasts a single cycle
  a_r2_erase_single: assert property (@(posedge clk) disable iff (!rst_sn)
    erase_go |=> !erase_go);
  // R4: program command only follows a done report
  a_r4_prog_after_done: assert property (@(posedge clk) disable iff (!rst_sn)
    prog_go |-> $past(op_done));
  // R10: every command is issued with I/O disabled
  a_r10_cmd_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    (erase_go || prog_go || recall_go) |-> busy);
endmodule

// File: rtl/su_unlock_top.sv
module su_unlock_top #(
  parameter int ADDR_W = 16,
  parameter int NPRE   = 5,
  parameter logic [NPRE*ADDR_W-1:0] PREFIX =
    {16'h703F, 16'h7C1F, 16'h83E0, 16'hB1C7, 16'h4E38},
  parameter logic [ADDR_W-1:0] KEY_ST = 16'h8FC0,
  parameter logic [ADDR_W-1:0] KEY_RC = 16'h4C63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_rd,
  input  logic              oe_rd,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              op_done,
  output logic              erase_start,
  output logic              prog_start,
  output logic              recall_start,
  output logic              io_dis
);
  logic rst_sn;
  logic acc_rd;
  logic hit_store, hit_recall;

  // R9: either strobe completes a read; both together are one read
  assign acc_rd = ce_rd | oe_rd;

  su_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  su_match #(
    .ADDR_W (ADDR_W),
    .NPRE   (NPRE),
    .PREFIX (PREFIX),
    .KEY_ST (KEY_ST),
    .KEY_RC (KEY_RC)
  ) u_match (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .acc_rd     (acc_rd),
    .acc_wr     (wr_evt),
    .addr       (acc_addr),
    .blocked    (io_dis),
    .op_done    (op_done),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  su_opseq u_seq (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .op_done    (op_done),
    .erase_go   (erase_start),
    .prog_go    (prog_start),
    .recall_go  (recall_start),
    .busy       (io_dis)
  );

  // R5: a recall command is followed by I/O disable
  a_r5_recall_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    recall_start |=> io_dis);
endmodule

// File: tb/sim_su_unlock_top.sv
module sim_su_unlock_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_rd = 1'b0, oe_rd = 1'b0, wr_evt = 1'b0, op_done = 1'b0;
  logic [15:0] acc_addr = '0;
  logic erase_start, prog_start, recall_start, io_dis;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit mon_on = 1'b0;
  bit done_flag = 1'b0;

  int    q_kind[$];
  int    q_cyc[$];
  string q_req[$];

  localparam logic [15:0] PFX [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  su_unlock_top u0 (
    .clk(clk), .rst_n(rst_n), .ce_rd(ce_rd), .oe_rd(oe_rd), .wr_evt(wr_evt),
    .acc_addr(acc_addr), .op_done(op_done), .erase_start(erase_start),
    .prog_start(prog_start), .recall_start(recall_start), .io_dis(io_dis)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input int kind, input string req);
    q_kind.push_back(kind);
    q_cyc.push_back(last_cyc);
    q_req.push_back(req);
  endtask

  // monitor: pops expected commands as the design produces them
  task automatic score(input int kind);
    if (q_kind.size() == 0) begin
      check(1'b0, "unexpected command", kind, -1);
    end else begin
      int ek = q_kind.pop_front();
      int ec = q_cyc.pop_front();
      string er = q_req.pop_front();
      check(ek == kind, er, kind, ek);
      check(ec == cyc, er, cyc, ec);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (erase_start)  score(0);
      if (prog_start)   score(1);
      if (recall_start) score(2);
    end
  end

  // mode: 0 ce read, 1 oe read, 2 write, 3 ce and oe read
  task automatic acc(input int mode, input logic [15:0] a);
    acc_addr = a;
    ce_rd    = (mode == 0 || mode == 3);
    oe_rd    = (mode == 1 || mode == 3);
    wr_evt   = (mode == 2);
    last_cyc = cyc + 1;
    @(negedge clk);
    ce_rd = 1'b0; oe_rd = 1'b0; wr_evt = 1'b0;
  endtask

  task automatic pfx(input int mode, input int from, input int upto);
    for (int i = from; i < upto; i++) acc(mode, PFX[i]);
  endtask

  task automatic done_pulse();
    op_done  = 1'b1;
    last_cyc = cyc + 1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_store(input string req);
    idle(2);
    done_pulse();
    expect_cmd(1, req);
    check(io_dis == 1'b1, req, io_dis, 1);
    idle(2);
    done_pulse();
    check(io_dis == 1'b0, req, io_dis, 0);
  endtask

  initial begin
    #(8 * 50000);
    check(1'b0, "watchdog", 0, 1);
    if (!done_flag) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1
    check({erase_start, prog_start, recall_start, io_dis} == 4'b0, "R1", io_dis, 0);
    mon_on = 1'b1;

    // R2 and R4: store
    pfx(0, 0, 5);
    acc(0, 16'h8FC0);
    expect_cmd(0, "R2");
    check(io_dis == 1'b1, "R2", io_dis, 1);
    finish_store("R4");

    // R3 and R5: recall, reads marked by output enable
    pfx(1, 0, 5);
    acc(1, 16'h4C63);
    expect_cmd(2, "R3");
    check(io_dis == 1'b1, "R3", io_dis, 1);
    idle(3);
    done_pulse();
    check(io_dis == 1'b0, "R5", io_dis, 0);

    // R6: write aborts
    pfx(0, 0, 3);
    acc(2, 16'h1234);
    pfx(0, 3, 5);
    acc(0, 16'h8FC0);
    idle(1);
    check(io_dis == 1'b0, "R6", io_dis, 0);

    // R7: wrong read aborts
    pfx(0, 0, 4);
    acc(0, 16'h0000);
    pfx(0, 4, 5);
    acc(0, 16'h4C63);
    idle(1);
    check(io_dis == 1'b0, "R7", io_dis, 0);

    // R8: restart mid-prefix
    pfx(0, 0, 3);
    pfx(0, 0, 5);
    acc(0, 16'h8FC0);
    expect_cmd(0, "R8");
    finish_store("R8");
    // R8: restart in the sixth position
    pfx(0, 0, 5);
    pfx(0, 0, 5);
    acc(0, 16'h4C63);
    expect_cmd(2, "R8");
    idle(2);
    done_pulse();
    check(io_dis == 1'b0, "R8", io_dis, 0);

    // R9: both strobes at once count once each cycle
    pfx(3, 0, 5);
    acc(3, 16'h4C63);
    expect_cmd(2, "R9");
    idle(1);
    done_pulse();
    check(io_dis == 1'b0, "R9", io_dis, 0);

    // R10: accesses while disabled are ignored
    pfx(0, 0, 5);
    acc(0, 16'h8FC0);
    expect_cmd(0, "R10");
    pfx(0, 0, 5);
    acc(0, 16'h8FC0);
    acc(2, 16'h4E38);
    done_pulse();
    expect_cmd(1, "R10");
    pfx(0, 0, 5);
    done_pulse();
    check(io_dis == 1'b0, "R10", io_dis, 0);
    acc(0, 16'h8FC0);
    idle(1);
    check(io_dis == 1'b0, "R10", io_dis, 0);

    // R11: done while idle clears progress, no pulse
    pfx(0, 0, 3);
    done_pulse();
    pfx(0, 3, 5);
    acc(0, 16'h8FC0);
    idle(1);
    check(io_dis == 1'b0, "R11", io_dis, 0);

    // R12: unknown sixth address, then a valid pattern
    pfx(0, 0, 5);
    acc(0, 16'h1111);
    idle(1);
    check(io_dis == 1'b0, "R12", io_dis, 0);
    pfx(0, 0, 5);
    acc(0, 16'h8FC0);
    expect_cmd(0, "R12");
    finish_store("R12");

    idle(3);
    check(q_kind.size() == 0, "pending commands", q_kind.size(), 0);
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule